// File: doc/BRIEF.md
# UART Register Front End

This block is the processor-facing side of a small serial port. A one-access-per-cycle bus reaches four 32-bit registers in a 16-byte window. The registers are the receive data register, the transmit data register, a read-only status word and a control word. Bytes from the receive engine enter an eight-entry first-in first-out store, and bus reads of the receive register take them out. A bus write to the transmit register hands its low byte to the transmit engine as a one-cycle strobe. The serial shifting, the baud timing and the line error detection sit outside this block.

A sticky pending flag records that something needs attention. Either received data waiting in the store or a new transmit write sets it. The interrupt line shows the flag when the control word enables it. A read of the status word acknowledges the flag. The flag clears on that read unless received data is still waiting.

A small sequencer tracks the access accepted in each cycle. It has four states. SEQ_IDLE means no access. SEQ_READ_RESP means a read was taken, so read data is returned now. SEQ_WRITE_DONE means a legal write was taken. SEQ_WRITE_FAULT means a write to the status word was refused. Every state moves to the next state on each clock edge: to SEQ_READ_RESP on a read, to SEQ_WRITE_FAULT on a status write, to SEQ_WRITE_DONE on any other write, and to SEQ_IDLE when no access is made.

Top module: `uart_regfront`

## Requirements
- R1: The register index is bus_addr[3:2]: 0 is receive data, 1 is transmit data, 2 is status and 3 is control. A read presents its data on bus_rdata with bus_rvalid high for exactly the cycle after the request. A write never raises bus_rvalid.
- R2: The status word has these bits. Bit 0 is high when the receive store holds at least one byte. Bit 1 is high when it holds eight bytes. Bit 2 always reads 1 (transmit empty). Bit 3 reads 0 (transmit full). Bit 4 is the pending flag. Bits 5 to 7 are reserved for overrun, frame and parity errors and read 0. Bits 31 to 8 read 0.
- R3: A cycle with rx_valid high and rx_ready high stores rx_byte. Reads of the receive register return the stored bytes oldest first.
- R4: rx_ready is low exactly while eight bytes are held. A byte offered while eight bytes are held is dropped, and the stored contents are unchanged.
- R5: A read of the receive register while the store is empty leaves it empty. The read returns the slot at the write position, which still holds whatever byte was last written there.
- R6: A control write keeps all 32 bits, which read back unchanged. When bit 1 of the written value is set, the receive store is emptied and its write position returns to slot 0.
- R7: A transmit write drives tx_strobe high for one cycle in the cycle after the write, with tx_byte equal to bus_wdata[7:0]. The transmit register reads back the full written word.
- R8: The pending flag is set by a transmit write and is held set while the receive store is non-empty. A status read returns the flag as it was before the read, then clears it unless bytes remain in the store.
- R9: irq is high exactly when the pending flag and control bit 4 are both set.
- R10: A write to the status word changes no register or flag. bus_err is high for the one cycle after that write.
- R11: After a synchronous reset the store is empty, the control word, the transmit register and the pending flag are zero, irq is low and rx_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | An access is requested this cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 4 | Byte address in the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data is valid this cycle |
| bus_err | output | 1 | The previous cycle held a refused status write |
| rx_byte | input | 8 | Byte from the receive engine |
| rx_valid | input | 1 | rx_byte is offered this cycle |
| rx_ready | output | 1 | The store has room for a byte |
| tx_byte | output | 8 | Byte for the transmit engine |
| tx_strobe | output | 1 | tx_byte is valid for this one cycle |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume at most one bus access per cycle. They also assume that rx_valid may be raised in any cycle, including while the store is full and in the same cycle as a receive read or a flush. The bench drives every input on the falling clock edge. It keeps each bus access to a single cycle and returns bus_valid low between accesses. It offers received bytes one pulse at a time, which also covers the offer that the full store must drop.

// File: rtl/uart_regfront_pkg.sv
package uart_regfront_pkg;

    // Register index, taken from byte address bits [3:2].
    typedef enum logic [1:0] {
        REG_RXDATA  = 2'd0,
        REG_TXDATA  = 2'd1,
        REG_STATUS  = 2'd2,
        REG_CONTROL = 2'd3
    } reg_idx_e;

    // Status word bit positions.
    localparam int ST_RX_VALID = 0;
    localparam int ST_RX_FULL  = 1;
    localparam int ST_TX_EMPTY = 2;
    localparam int ST_TX_FULL  = 3;
    localparam int ST_PENDING  = 4;
    localparam int ST_OVERRUN  = 5;
    localparam int ST_FRAME    = 6;
    localparam int ST_PARITY   = 7;

    // Control word bit positions.
    localparam int CT_TX_CLEAR = 0;
    localparam int CT_RX_CLEAR = 1;
    localparam int CT_IRQ_EN   = 4;

    // Bus access sequencer states.
    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_READ_RESP,
        SEQ_WRITE_DONE,
        SEQ_WRITE_FAULT
    } seq_state_e;

    // One-hot decode of the access accepted this cycle.
    typedef struct packed {
        logic rd_rx;
        logic rd_tx;
        logic rd_stat;
        logic rd_ctrl;
        logic wr_tx;
        logic wr_ctrl;
        logic wr_bad;
    } access_t;

endpackage

// File: rtl/uart_bus_seq.sv
module uart_bus_seq
    import uart_regfront_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output access_t           acc,
    output logic              rsp_valid,
    output logic              rsp_err
);

    localparam int IDX_W = 2;

    seq_state_e state_q, state_d;
    logic [IDX_W-1:0] idx_bits;
    reg_idx_e idx;

    // Word index: byte address shifted down by two.
    assign idx_bits = IDX_W'(req_addr >> 2);
    assign idx      = reg_idx_e'(idx_bits);

    // Access decode for the current request.
    always_comb begin
        acc = '0;
        if (req_valid) begin
            unique case (idx)
                REG_RXDATA:  if (req_write) acc.wr_bad = 1'b0; else acc.rd_rx = 1'b1;
                REG_TXDATA:  if (req_write) acc.wr_tx = 1'b1;  else acc.rd_tx = 1'b1;
                REG_STATUS:  if (req_write) acc.wr_bad = 1'b1; else acc.rd_stat = 1'b1;
                REG_CONTROL: if (req_write) acc.wr_ctrl = 1'b1; else acc.rd_ctrl = 1'b1;
            endcase
        end
    end

    // Next state: records the kind of access taken this cycle.
    always_comb begin
        if (!req_valid)
            state_d = SEQ_IDLE;
        else if (!req_write)
            state_d = SEQ_READ_RESP;
        else if (idx == REG_STATUS)
            state_d = SEQ_WRITE_FAULT;
        else
            state_d = SEQ_WRITE_DONE;
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= SEQ_IDLE;
        else
            state_q <= state_d;
    end

    // Response outputs decoded from the state.
    always_comb begin
        rsp_valid = 1'b0;
        rsp_err   = 1'b0;
        unique case (state_q)
            SEQ_IDLE:        ;
            SEQ_READ_RESP:   rsp_valid = 1'b1;
            SEQ_WRITE_DONE:  ;
            SEQ_WRITE_FAULT: rsp_err = 1'b1;
        endcase
    end

    AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> (rsp_valid && !rsp_err)); // R1
    AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write) |=> !rsp_valid); // R1
    AST_FAULT_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && idx == REG_STATUS) |=> rsp_err); // R10

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
    parameter int DEPTH  = 8,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [BYTE_W-1:0] push_data,
    input  logic              pop,
    input  logic              flush,
    output logic [BYTE_W-1:0] pop_data,
    output logic              ready,
    output logic              nonempty,
    output logic              full,
    output logic              nonempty_nxt
);

    // DEPTH must be a power of two: the write pointer wraps naturally.
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

    logic [BYTE_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wp_q, wp_d, rd_ptr;
    logic [CNT_W-1:0]  count_q, count_d, count_step;
    logic              push_ok, pop_ok;

    assign push_ok = push && !flush && (count_q < CNT_MAX);
    assign pop_ok  = pop && !flush && (count_q != '0);

    // Oldest entry sits "count" slots behind the write pointer.
    assign rd_ptr   = wp_q - count_q[PTR_W-1:0];
    assign pop_data = mem[rd_ptr];

    always_comb begin
        unique case ({push_ok, pop_ok})
            2'b10:   count_step = count_q + CNT_W'(1);
            2'b01:   count_step = count_q - CNT_W'(1);
            default: count_step = count_q;
        endcase
        count_d = flush ? '0 : count_step;
        if (flush)
            wp_d = '0;
        else if (push_ok)
            wp_d = wp_q + PTR_W'(1);
        else
            wp_d = wp_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q    <= '0;
            count_q <= '0;
        end else begin
            wp_q    <= wp_d;
            count_q <= count_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= '0;
        end else if (push_ok) begin
            mem[wp_q] <= push_data;
        end
    end

    assign ready        = (count_q < CNT_MAX);
    assign nonempty     = (count_q != '0);
    assign full         = (count_q == CNT_MAX);
    assign nonempty_nxt = (count_d != '0);

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        count_q <= CNT_MAX); // R3
    AST_PUSH_COUNTS: assert property (@(posedge clk) disable iff (rst)
        (push && ready && !pop && !flush) |=> (count_q == $past(count_q) + CNT_W'(1))); // R3
    AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop && !flush) |=> (full && $stable(wp_q))); // R4
    AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!nonempty && pop && !push && !flush) |=> (count_q == '0)); // R5
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        flush |=> (count_q == '0 && wp_q == '0)); // R6
    AST_RESET_EMPTY: assert property (@(posedge clk)
        rst |=> (count_q == '0 && wp_q == '0)); // R11

endmodule

// File: rtl/uart_reg_bank.sv
module uart_reg_bank
    import uart_regfront_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  access_t           acc,
    input  logic [DATA_W-1:0] wdata,
    input  logic [BYTE_W-1:0] fifo_data,
    input  logic              fifo_nonempty,
    input  logic              fifo_full,
    input  logic              fifo_nonempty_nxt,
    output logic              flush,
    output logic [DATA_W-1:0] rdata,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              tx_strobe,
    output logic              irq
);

    logic [DATA_W-1:0] ctrl_q, tx_q, status_w, rd_sel;
    logic              pend_q;
    logic              any_rd;

    assign flush = acc.wr_ctrl && wdata[CT_RX_CLEAR];

    // Status word composition; error bits are reserved and read zero.
    always_comb begin
        status_w              = '0;
        status_w[ST_RX_VALID] = fifo_nonempty;
        status_w[ST_RX_FULL]  = fifo_full;
        status_w[ST_TX_EMPTY] = 1'b1;
        status_w[ST_TX_FULL]  = 1'b0;
        status_w[ST_PENDING]  = pend_q;
        status_w[ST_OVERRUN]  = 1'b0;
        status_w[ST_FRAME]    = 1'b0;
        status_w[ST_PARITY]   = 1'b0;
    end

    always_comb begin
        if (acc.rd_rx)
            rd_sel = DATA_W'(fifo_data);
        else if (acc.rd_tx)
            rd_sel = tx_q;
        else if (acc.rd_stat)
            rd_sel = status_w;
        else if (acc.rd_ctrl)
            rd_sel = ctrl_q;
        else
            rd_sel = '0;
    end

    assign any_rd = acc.rd_rx | acc.rd_tx | acc.rd_stat | acc.rd_ctrl;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata     <= '0;
            ctrl_q    <= '0;
            tx_q      <= '0;
            tx_byte   <= '0;
            tx_strobe <= 1'b0;
            pend_q    <= 1'b0;
        end else begin
            if (any_rd)
                rdata <= rd_sel;
            if (acc.wr_ctrl)
                ctrl_q <= wdata;
            if (acc.wr_tx) begin
                tx_q    <= wdata;
                tx_byte <= wdata[BYTE_W-1:0];
            end
            tx_strobe <= acc.wr_tx;
            // Sticky: set by transmit writes and waiting data,
            // acknowledged by a status read.
            pend_q <= acc.wr_tx | fifo_nonempty_nxt | (pend_q & ~acc.rd_stat);
        end
    end

    assign irq = pend_q & ctrl_q[CT_IRQ_EN];

    AST_TX_STROBE: assert property (@(posedge clk) disable iff (rst)
        acc.wr_tx |=> (tx_strobe && tx_byte == $past(wdata[BYTE_W-1:0]))); // R7
    AST_PEND_WITH_DATA: assert property (@(posedge clk) disable iff (rst)
        fifo_nonempty |-> pend_q); // R8
    AST_PEND_ACK: assert property (@(posedge clk) disable iff (rst)
        (acc.rd_stat && !fifo_nonempty_nxt && !acc.wr_tx) |=> !pend_q); // R8
    AST_STATUS_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
        acc.wr_bad |=> ($stable(ctrl_q) && $stable(tx_q) && $stable(pend_q))); // R10

endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
    import uart_regfront_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 32,
    parameter int BYTE_W     = 8,
    parameter int FIFO_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    output logic              bus_err,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_valid,
    output logic              rx_ready,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              tx_strobe,
    output logic              irq
);

    access_t           acc;
    logic [BYTE_W-1:0] fifo_data;
    logic              fifo_nonempty, fifo_full, fifo_nonempty_nxt, flush;

    uart_bus_seq #(
        .ADDR_W (ADDR_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (bus_valid),
        .req_write (bus_write),
        .req_addr  (bus_addr),
        .acc       (acc),
        .rsp_valid (bus_rvalid),
        .rsp_err   (bus_err)
    );

    uart_rx_fifo #(
        .DEPTH  (FIFO_DEPTH),
        .BYTE_W (BYTE_W)
    ) u_fifo (
        .clk          (clk),
        .rst          (rst),
        .push         (rx_valid),
        .push_data    (rx_byte),
        .pop          (acc.rd_rx),
        .flush        (flush),
        .pop_data     (fifo_data),
        .ready        (rx_ready),
        .nonempty     (fifo_nonempty),
        .full         (fifo_full),
        .nonempty_nxt (fifo_nonempty_nxt)
    );

    uart_reg_bank #(
        .DATA_W (DATA_W),
        .BYTE_W (BYTE_W)
    ) u_regs (
        .clk               (clk),
        .rst               (rst),
        .acc               (acc),
        .wdata             (bus_wdata),
        .fifo_data         (fifo_data),
        .fifo_nonempty     (fifo_nonempty),
        .fifo_full         (fifo_full),
        .fifo_nonempty_nxt (fifo_nonempty_nxt),
        .flush             (flush),
        .rdata             (bus_rdata),
        .tx_byte           (tx_byte),
        .tx_strobe         (tx_strobe),
        .irq               (irq)
    );

    AST_READY_FOLLOWS_FULL: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_ready && !bus_valid) |=> !rx_ready); // R4
    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (!irq && rx_ready && !bus_rvalid && !bus_err && !tx_strobe)); // R11

endmodule

// File: tb/uart_regfront_bench.sv
`timescale 1ns/1ps
module uart_regfront_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid, bus_err;
    logic [7:0]  rx_byte = '0;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic [7:0]  tx_byte;
    logic        tx_strobe, irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    uart_regfront u_uart_regfront (
        .clk        (clk),
        .rst        (rst),
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .bus_err    (bus_err),
        .rx_byte    (rx_byte),
        .rx_valid   (rx_valid),
        .rx_ready   (rx_ready),
        .tx_byte    (tx_byte),
        .tx_strobe  (tx_strobe),
        .irq        (irq)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard when read data appears.
    always @(negedge clk) begin
        if (!rst && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R1 unexpected read response", bus_rdata, 32'h0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(bus_rdata === e, t, bus_rdata, e);
            end
        end
    end

    task automatic bus_read(input logic [3:0] addr, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = addr;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic bus_wr(input logic [3:0] addr, input logic [31:0] data);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = addr; bus_wdata = data;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rx_push(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    localparam logic [3:0] A_RX = 4'h0, A_TX = 4'h4, A_ST = 4'h8, A_CT = 4'hC;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check(rx_ready === 1'b1, "R11 rx_ready after reset", {31'b0, rx_ready}, 32'h1);
        check(irq === 1'b0, "R11 irq after reset", {31'b0, irq}, 32'h0);
        bus_read(A_ST, 32'h0000_0004, "R11 R2 status after reset");
        bus_read(A_CT, 32'h0, "R11 control after reset");

        // R3 ordering, R8 pending with data
        rx_push(8'h11); rx_push(8'h22); rx_push(8'h33);
        bus_read(A_ST, 32'h0000_0015, "R2 R8 status with three bytes");
        bus_read(A_RX, 32'h11, "R3 first byte");
        bus_read(A_RX, 32'h22, "R3 second byte");
        bus_read(A_RX, 32'h33, "R3 third byte");
        bus_read(A_ST, 32'h0000_0014, "R8 pending kept until status read");
        bus_read(A_ST, 32'h0000_0004, "R8 pending cleared by status read");

        // R4 full and drop, R5 stale empty read (first byte lands in slot 3)
        for (int i = 0; i < 8; i++) rx_push(8'hA0 + 8'(i));
        check(rx_ready === 1'b0, "R4 rx_ready low when full", {31'b0, rx_ready}, 32'h0);
        bus_read(A_ST, 32'h0000_0017, "R2 R4 status when full");
        rx_push(8'hEE);
        for (int i = 0; i < 8; i++) bus_read(A_RX, 32'hA0 + i, "R3 R4 drained byte");
        check(rx_ready === 1'b1, "R4 rx_ready back after drain", {31'b0, rx_ready}, 32'h1);
        bus_read(A_RX, 32'hA0, "R5 empty read returns stale slot");
        bus_read(A_ST, 32'h0000_0014, "R5 count stays zero after empty read");
        bus_read(A_ST, 32'h0000_0004, "R8 pending acknowledged");

        // R9 interrupt gating, R6 control and flush
        bus_wr(A_CT, 32'h0000_0010);
        check(irq === 1'b0, "R9 irq low with no pending", {31'b0, irq}, 32'h0);
        rx_push(8'h55);
        check(irq === 1'b1, "R9 irq with data and enable", {31'b0, irq}, 32'h1);
        bus_wr(A_CT, 32'h0000_0012);
        check(rx_ready === 1'b1, "R6 flush frees store", {31'b0, rx_ready}, 32'h1);
        bus_read(A_ST, 32'h0000_0014, "R6 store empty after flush");
        bus_read(A_CT, 32'h0000_0012, "R6 control reads back");
        check(irq === 1'b0, "R9 irq cleared by status read", {31'b0, irq}, 32'h0);

        // R7 transmit strobe, R8 pending from transmit
        bus_wr(A_TX, 32'h1234_56C3);
        check(tx_strobe === 1'b1, "R7 strobe after write", {31'b0, tx_strobe}, 32'h1);
        check(tx_byte === 8'hC3, "R7 tx byte", {24'b0, tx_byte}, 32'hC3);
        check(bus_rvalid === 1'b0, "R1 no read response to write", {31'b0, bus_rvalid}, 32'h0);
        check(irq === 1'b1, "R8 R9 transmit write sets pending", {31'b0, irq}, 32'h1);
        @(negedge clk);
        check(tx_strobe === 1'b0, "R7 strobe one cycle", {31'b0, tx_strobe}, 32'h0);
        bus_read(A_TX, 32'h1234_56C3, "R7 transmit readback");

        // R10 illegal status write
        bus_wr(A_ST, 32'hFFFF_FFFF);
        check(bus_err === 1'b1, "R10 error flagged", {31'b0, bus_err}, 32'h1);
        @(negedge clk);
        check(bus_err === 1'b0, "R10 error one cycle", {31'b0, bus_err}, 32'h0);
        bus_read(A_CT, 32'h0000_0012, "R10 control unchanged");
        bus_read(A_ST, 32'h0000_0014, "R10 status unchanged");

        // R1 low address bits ignored
        bus_read(4'hE, 32'h0000_0012, "R1 byte offset in control word");
        bus_read(4'h9, 32'h0000_0004, "R1 byte offset in status word");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R1 all reads answered", exp_q.size(), 32'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=0", 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule